// File: doc/BRIEF.md
# Programmable Serial Baud Generator

This block turns the system clock into the timing source for an asynchronous serial port. A 13-bit divisor `D` sets the rate. A modulus counter produces one pulse every `D` system clocks. A divide-by-2 stage turns those pulses into a receive sampling tick at sixteen times the bit rate. A divide-by-16 stage turns the sampling ticks into a transmit bit tick. The bit rate is therefore f_sys / (32 * D).

The divisor input may change at any time. Any change throws away the partial count in all three stages, and the new rate starts from a clean state on the next count cycle. A divisor of zero holds the generator idle, so neither tick fires. Both tick outputs are registered and are one system clock wide.

Top module: `serial_baud_gen`

## Requirements
- R1: While `rst` is high, and afterwards until the first full period has elapsed, `sample_tick` and `bit_tick` are low.
- R2: With a constant nonzero divisor D, for any value from 1 to 8191 (13 bits), `sample_tick` pulses exactly once every 2*D system clocks.
- R3: While the divisor is zero, neither `sample_tick` nor `bit_tick` ever goes high.
- R4: `bit_tick` pulses on every 16th `sample_tick`, in the same cycle as that sample tick, so its period is 32*D clocks.
- R5: After the divisor takes a new nonzero value D, or after reset is released, the first `sample_tick` is seen after the (2*D+1)-th rising clock edge and the first `bit_tick` after the (32*D+1)-th. The first of those edges is the one that detects the change.
- R6: Each tick is high for exactly one system clock cycle.
- R7: When the divisor returns from zero to a nonzero value, counting starts from the reset state. No partial count from before the zero period survives, so the timing of R5 holds.
- R8: A change from one nonzero divisor to another in the middle of a period discards the partial count in every stage, so the timing of R5 holds for the new value.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| divisor | input | 13 | Rate divisor D; 0 stops the generator |
| sample_tick | output | 1 | One-cycle pulse at 16 times the bit rate |
| bit_tick | output | 1 | One-cycle pulse at the bit rate |

## Verification
Every divisor from 1 to 12 is held for more than two bit periods. Both outputs are compared with an arithmetic expectation at every clock edge, which separates a wrong modulus, a missing divide-by-2 and a wrong divide-by-16 count. The largest divisor, 8191, checks that the full 13-bit width is compared correctly. Changes in mid-period between two nonzero divisors, and a trip through zero that is left with a partial count behind, separate a design that restarts cleanly from one that keeps stale state. A long run with a zero divisor confirms that both ticks stay silent.

// File: rtl/baud_pkg.sv
package baud_pkg;
  localparam int unsigned BG_DIV_W      = 13;
  localparam int unsigned BG_PREDIV     = 2;
  localparam int unsigned BG_OVERSAMPLE = 16;
endpackage

// File: rtl/bg_modcount.sv
module bg_modcount #(
  parameter int unsigned W = 13
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         clear,
  input  logic [W-1:0] limit,
  output logic         wrap
);
  logic [W-1:0] cnt_q;
  logic         at_end;

  assign at_end = (cnt_q == limit - 1'b1);
  assign wrap   = !clear && at_end;

  always_ff @(posedge clk) begin
    if (rst || clear) begin
      cnt_q <= '0;
    end else if (at_end) begin
      cnt_q <= '0;
    end else begin
      cnt_q <= cnt_q + 1'b1;
    end
  end
endmodule

// File: rtl/bg_stage.sv
module bg_stage #(
  parameter int unsigned RATIO = 2
) (
  input  logic clk,
  input  logic rst,
  input  logic clear,
  input  logic in_pulse,
  output logic out_pulse
);
  localparam int unsigned CW = (RATIO > 1) ? $clog2(RATIO) : 1;

  generate
    if (RATIO <= 1) begin : g_pass
      assign out_pulse = in_pulse && !clear;
    end else begin : g_div
      logic [CW-1:0] cnt_q;
      logic          last;

      assign last      = (cnt_q == CW'(RATIO - 1));
      assign out_pulse = in_pulse && last && !clear;

      always_ff @(posedge clk) begin
        if (rst || clear) begin
          cnt_q <= '0;
        end else if (in_pulse) begin
          cnt_q <= last ? '0 : cnt_q + 1'b1;
        end
      end
    end
  endgenerate
endmodule

// File: rtl/serial_baud_gen.sv
module serial_baud_gen
  import baud_pkg::*;
#(
  parameter int unsigned DIV_W      = BG_DIV_W,
  parameter int unsigned PREDIV     = BG_PREDIV,
  parameter int unsigned OVERSAMPLE = BG_OVERSAMPLE
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [DIV_W-1:0] divisor,
  output logic             sample_tick,
  output logic             bit_tick
);
  logic [DIV_W-1:0] div_q;
  logic             halt;
  logic             mod_wrap;
  logic             sample_stb;
  logic             bit_stb;

  // Any divisor change, or a zero divisor, resets the whole chain.
  assign halt = (divisor == '0) || (divisor != div_q);

  always_ff @(posedge clk) begin
    if (rst) begin
      div_q <= '0;
    end else begin
      div_q <= divisor;
    end
  end

  bg_modcount #(.W(DIV_W)) modcnt_i (
    .clk   (clk),
    .rst   (rst),
    .clear (halt),
    .limit (divisor),
    .wrap  (mod_wrap)
  );

  bg_stage #(.RATIO(PREDIV)) prediv_i (
    .clk       (clk),
    .rst       (rst),
    .clear     (halt),
    .in_pulse  (mod_wrap),
    .out_pulse (sample_stb)
  );

  bg_stage #(.RATIO(OVERSAMPLE)) ovs_i (
    .clk       (clk),
    .rst       (rst),
    .clear     (halt),
    .in_pulse  (sample_stb),
    .out_pulse (bit_stb)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      sample_tick <= 1'b0;
      bit_tick    <= 1'b0;
    end else begin
      sample_tick <= sample_stb;
      bit_tick    <= bit_stb;
    end
  end
endmodule

// File: rtl/serial_baud_gen_chk.sv
module serial_baud_gen_chk #(
  parameter int unsigned DIV_W = 13
) (
  input logic             clk,
  input logic             rst,
  input logic [DIV_W-1:0] divisor,
  input logic             sample_tick,
  input logic             bit_tick
);
  p_sample_single_r6: assert property (@(posedge clk) disable iff (rst)
    sample_tick |=> !sample_tick);

  p_bit_single_r6: assert property (@(posedge clk) disable iff (rst)
    bit_tick |=> !bit_tick);

  p_bit_on_sample_r4: assert property (@(posedge clk) disable iff (rst)
    bit_tick |-> sample_tick);

  p_zero_quiet_r3: assert property (@(posedge clk) disable iff (rst)
    (divisor == '0) |=> (!sample_tick && !bit_tick));

  p_change_restart_r8: assert property (@(posedge clk) disable iff (rst)
    (divisor != $past(divisor)) |=> (!sample_tick && !bit_tick));

  always @(posedge clk) begin
    if (rst) begin
      a_reset_low_r1: assert (!sample_tick && !bit_tick || $past(!rst));
    end
  end
endmodule

bind serial_baud_gen serial_baud_gen_chk #(.DIV_W(DIV_W)) chk_i (
  .clk         (clk),
  .rst         (rst),
  .divisor     (divisor),
  .sample_tick (sample_tick),
  .bit_tick    (bit_tick)
);

// File: tb/serial_baud_gen_tb_top.sv
module serial_baud_gen_tb_top;
  localparam int DW = 13;

  logic          clk = 1'b0;
  logic          rst = 1'b1;
  logic [DW-1:0] divisor = '0;
  logic          sample_tick;
  logic          bit_tick;

  int checks = 0;
  int errors = 0;
  bit done   = 1'b0;

  always #2.5 clk = ~clk;

  serial_baud_gen dut_i (
    .clk         (clk),
    .rst         (rst),
    .divisor     (divisor),
    .sample_tick (sample_tick),
    .bit_tick    (bit_tick)
  );

  task automatic check(input bit ok, input string req, input string what,
                       input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  // Walk n edges after the current divisor was applied (edge 1 detects it).
  task automatic walk(input int d, input int n, input string req);
    int bad_s = 0, bad_b = 0, fs = -1, fb = -1, es = 0, eb = 0, as_ = 0, ab = 0;
    for (int k = 1; k <= n; k++) begin
      bit exp_s, exp_b;
      @(posedge clk);
      @(negedge clk);
      exp_s = (d != 0) && (k > 1) && ((k - 1) % (2 * d) == 0);
      exp_b = (d != 0) && (k > 1) && ((k - 1) % (32 * d) == 0);
      if (sample_tick !== exp_s) begin
        bad_s++;
        if (fs < 0) begin fs = k; as_ = sample_tick; es = exp_s; end
      end
      if (bit_tick !== exp_b) begin
        bad_b++;
        if (fb < 0) begin fb = k; ab = bit_tick; eb = exp_b; end
      end
    end
    check(bad_s == 0, req, $sformatf("sample_tick D=%0d first bad edge %0d", d, fs), as_, es);
    check(bad_b == 0, req, $sformatf("bit_tick D=%0d first bad edge %0d", d, fb), ab, eb);
  endtask

  task automatic apply(input int d);
    @(negedge clk);
    divisor = DW'(d);
  endtask

  initial begin
    divisor = 13'd3;
    for (int i = 0; i < 5; i++) begin
      @(negedge clk);
      check(!sample_tick && !bit_tick, "R1", "ticks during reset", sample_tick, 0);
    end
    rst = 1'b0;
    // R1 / R5: release from reset behaves as a fresh divisor
    walk(3, 32 * 3 * 2 + 2, "R1");

    // R2 R4 R5 R6: sweep small divisors
    for (int d = 1; d <= 12; d++) begin
      apply(d);
      walk(d, 32 * d * 2 + 2, "R2");
    end

    // R3: zero divisor stays silent
    apply(0);
    walk(0, 600, "R3");

    // R8: mid-period change between nonzero divisors
    apply(5);
    walk(5, 23, "R8");
    apply(7);
    walk(7, 32 * 7 + 20, "R8");
    apply(2);
    walk(2, 70, "R8");
    apply(6);
    walk(6, 32 * 6 * 2 + 2, "R8");

    // R7: zero period leaves no stale count
    apply(9);
    walk(9, 13, "R7");
    apply(0);
    walk(0, 20, "R7");
    apply(4);
    walk(4, 32 * 4 * 2 + 2, "R7");

    // R2 R5: full-width divisor, first sample ticks
    apply(8191);
    walk(8191, 2 * 8191 * 2 + 3, "R5");

    done = 1'b1;
  end

  initial begin
    fork
      wait (done);
      begin
        repeat (190000) @(posedge clk);
        checks++;
        errors++;
        $display("FAIL watchdog: actual timeout expected completion");
      end
    join_any
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule